// File: doc/BRIEF.md
# Power-of-Two Clock Divider Bank

This block derives a set of divided clocks from one reference clock. Each channel has a divide code and an enable bit. Both sit in a small byte-wide register window, and the windows for successive channels are one 256-byte step apart, above a common base address. A channel that is running produces the reference clock divided by 1, 2, 4, 8, 16, 32 or 64. The divided clock has equal high and low phases for every ratio above one.

Starting and stopping are both sequenced in reference cycles:

- After the enable bit is set, the channel waits (2 + 3·ratio) cycles and then starts.
- After the enable bit is cleared, the channel stops (3·ratio) cycles later.
- The output only ever starts or stops during its low phase, so no pulse is shortened.

The divide ratio is captured when a channel starts. Software may therefore rewrite the code at any time, and the new value takes effect on the next start. A per-channel running flag shows when the sequenced output is active.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every channel reads a divide code of 0 and a clear enable bit, and its clock output and running flag are low.
- R2: The divide code is bits [2:0] of offset 0x43 in a channel window. A write stores those three bits, and a read returns them with bits [7:3] as zero.
- R3: The enable is bit 7 of offset 0x46 in a channel window. A read returns the stored bit with bits [6:0] as zero. A write with bit 7 clear does not start the channel.
- R4: Channel n occupies addresses BASE + n·0x100 to BASE + n·0x100 + 0xFF. A write to any other offset, or to an address outside the channel windows, changes no state. A read of such an address returns 0.
- R5: Codes 0 and 1 both select ratio 1, and code n (2 to 7) selects ratio 2^(n-1).
- R6: The running flag rises exactly (2 + 3·ratio) reference edges after the edge that captures a write setting the enable bit of an idle channel.
- R7: The running flag falls exactly 3·ratio reference edges after the edge that captures a write clearing the enable bit of a running channel.
- R8: For ratios of 2 or more, the output first rises ratio/2 edges after the running flag rises, and then stays high for ratio/2 edges and low for ratio/2 edges. For ratio 1, the output follows the reference clock from the edge after the running flag rises.
- R9: After a disable, the output completes the high phase it is in and then holds low. It is low whenever the running flag is low.
- R10: A divide code written while a channel is enabled is stored and read back at once. The running ratio and the stop latency keep the old value, and the new ratio applies from the next enable.
- R11: Clearing the enable before the start latency has elapsed cancels the start. The running flag stays low and no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; all sequencing counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 16 | Byte address for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| div_clk | output | 3 | Divided clock, one bit per channel |
| div_running | output | 3 | Running flag, one bit per channel |

## Verification
Reads are combinational, so the bench checks read data in the same cycle as the address.

Within a channel, the running flag changes on a reference edge (2 + 3·ratio) edges after an enable write, or 3·ratio edges after a disable. The divided output changes on the edge ratio/2 after that. In the ratio-1 case the output is gated, so it is high during the reference high phase that follows the first running edge.

The bench stimulus changes inputs only on falling edges. A behavioural model records the edge index of each write and derives from those indices the expected flag and output for every edge. The bench samples both 2 ns after each rising edge, during the reference high phase, which is where the gated ratio-1 output can be seen. Separate latency counts measure the rise and fall distances directly, edge by edge from the write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_WAIT  = 2'd1,
      CH_RUN   = 2'd2,
      CH_DRAIN = 2'd3
   } ch_state_e;

   // code 0 and 1 both mean undivided; code n means 2^(n-1)
   function automatic int unsigned code_to_ratio(input int unsigned code);
      if (code <= 1) return 1;
      return 32'd1 << (code - 1);
   endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
   parameter int                NUM_CH    = 3,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                WIN_W     = 8,
   parameter int                CODE_W    = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000,
   parameter logic [WIN_W-1:0]  DIV_OFS   = 8'h43,
   parameter logic [WIN_W-1:0]  EN_OFS    = 8'h46,
   parameter int                EN_POS    = 7
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_i,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [DATA_W-1:0]              wdata_i,
   output logic [DATA_W-1:0]              rdata_o,
   output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
   output logic [NUM_CH-1:0]              en_o,
   output logic [NUM_CH-1:0]              en_nxt_o
);

   localparam int IDX_W = ADDR_W - WIN_W;

   if (EN_POS >= DATA_W) begin : g_bad_en_pos
      $error("enable bit position outside data width");
   end
   if (CODE_W > DATA_W) begin : g_bad_code_w
      $error("divide code wider than data bus");
   end
   if (DIV_OFS == EN_OFS) begin : g_bad_ofs
      $error("divide and enable offsets collide");
   end
   if (NUM_CH > (1 << IDX_W)) begin : g_bad_num_ch
      $error("not enough address bits for the channel windows");
   end

   logic [IDX_W-1:0]  win;
   logic [WIN_W-1:0]  ofs;
   logic [NUM_CH-1:0] sel;
   logic [NUM_CH-1:0] wr_div;
   logic [NUM_CH-1:0] wr_en;
   logic [NUM_CH-1:0] hit_def;
   logic              unused_wdata;

   assign win          = addr_i[ADDR_W-1:WIN_W] - BASE_ADDR[ADDR_W-1:WIN_W];
   assign ofs          = addr_i[WIN_W-1:0];
   assign unused_wdata = ^wdata_i;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign sel[ch]      = (win == IDX_W'(ch));
      assign wr_div[ch]   = wr_i && sel[ch] && (ofs == DIV_OFS);
      assign wr_en[ch]    = wr_i && sel[ch] && (ofs == EN_OFS);
      assign hit_def[ch]  = sel[ch] && ((ofs == DIV_OFS) || (ofs == EN_OFS));
      assign en_nxt_o[ch] = wr_en[ch] ? wdata_i[EN_POS] : en_o[ch];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_o[ch] <= '0;
            en_o[ch]   <= 1'b0;
         end else begin
            en_o[ch] <= en_nxt_o[ch];
            if (wr_div[ch]) code_o[ch] <= wdata_i[CODE_W-1:0];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (sel[ch] && (ofs == DIV_OFS)) rdata_o[CODE_W-1:0] = code_o[ch];
         if (sel[ch] && (ofs == EN_OFS))  rdata_o[EN_POS]     = en_o[ch];
      end
   end

   // a write that lands on no defined register leaves every register unchanged
   assert_ignored_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !(|hit_def)) |=> ($stable(code_o) && $stable(en_o)));

   // a defined enable write is visible in the stored bit on the next cycle
   assert_enable_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en) |=> ((en_o & $past(wr_en)) == ($past(wr_en) & {NUM_CH{$past(wdata_i[EN_POS])}})));

endmodule

// File: rtl/clkdiv_icg.sv
module clkdiv_icg (
   input  logic clk_i,
   input  logic en_i,
   output logic clk_o
);

   logic en_l;

   // transparent while the clock is low, so the gate opens and closes only between pulses
   always_latch begin
      if (!clk_i) en_l <= en_i;
   end

   assign clk_o = clk_i & en_l;

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_nxt_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              clk_o,
   output logic              running_o
);

   import clkdiv_pkg::*;

   localparam int MAX_RATIO = 1 << ((1 << CODE_W) - 2);
   localparam int DLY_MAX   = 2 + 3 * MAX_RATIO;
   localparam int CNT_W     = $clog2(DLY_MAX + 1);

   if (CODE_W < 2 || CODE_W > 4) begin : g_bad_code_w
      $error("divide code width must be 2 to 4 bits");
   end

   ch_state_e         state_q;
   logic [CNT_W-1:0]  dly_q;
   logic [CNT_W-1:0]  new_ratio;
   logic [CNT_W-1:0]  act_ratio;
   logic [CNT_W-1:0]  half;
   logic [CNT_W-1:0]  half_q;
   logic [CODE_W-1:0] act_code_q;
   logic              tog_q;
   logic              is_one;
   logic              advance;
   logic              gate_en;
   logic              gated_clk;

   assign new_ratio = CNT_W'(code_to_ratio(32'(code_i)));
   assign act_ratio = CNT_W'(code_to_ratio(32'(act_code_q)));
   assign half      = act_ratio >> 1;
   assign is_one    = (act_ratio == CNT_W'(1));

   // start/stop sequencing; the ratio is frozen when a start begins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= CH_IDLE;
         dly_q      <= '0;
         act_code_q <= '0;
      end else begin
         unique case (state_q)
            CH_IDLE: begin
               if (en_nxt_i) begin
                  state_q    <= CH_WAIT;
                  act_code_q <= code_i;
                  dly_q      <= CNT_W'(2) + CNT_W'(3) * new_ratio - CNT_W'(1);
               end
            end
            CH_WAIT: begin
               if (!en_nxt_i)          state_q <= CH_IDLE;
               else if (dly_q == '0)   state_q <= CH_RUN;
               else                    dly_q   <= dly_q - CNT_W'(1);
            end
            CH_RUN: begin
               if (!en_nxt_i) begin
                  state_q <= CH_DRAIN;
                  dly_q   <= CNT_W'(3) * act_ratio - CNT_W'(1);
               end
            end
            CH_DRAIN: begin
               if (dly_q == '0) state_q <= CH_IDLE;
               else             dly_q   <= dly_q - CNT_W'(1);
            end
            default: state_q <= CH_IDLE;
         endcase
      end
   end

   // half-period toggle; while draining it only finishes a high phase
   assign advance = !is_one &&
                    ((state_q == CH_RUN) || ((state_q == CH_DRAIN) && tog_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= '0;
         tog_q  <= 1'b0;
      end else if (state_q == CH_WAIT) begin
         half_q <= '0;
         tog_q  <= 1'b0;
      end else if (advance) begin
         if (half_q == half - CNT_W'(1)) begin
            half_q <= '0;
            tog_q  <= ~tog_q;
         end else begin
            half_q <= half_q + CNT_W'(1);
         end
      end
   end

   assign gate_en = (state_q == CH_RUN) && is_one;

   clkdiv_icg u_icg (
      .clk_i (clk),
      .en_i  (gate_en),
      .clk_o (gated_clk)
   );

   assign clk_o     = is_one ? gated_clk : tog_q;
   assign running_o = (state_q == CH_RUN) || (state_q == CH_DRAIN);

   assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running_o) |-> !tog_q);

   assert_stop_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running_o) |-> !tog_q);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !running_o |-> !tog_q);

   assert_hold_ratio_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (running_o && $past(running_o)) |-> $stable(act_code_q));

   assert_half_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == CH_RUN) && !is_one) |-> (half_q < half));

   assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == CH_WAIT) && !en_nxt_i) |=> (state_q == CH_IDLE));

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
   parameter int                NUM_CH    = 3,
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                WIN_W     = 8,
   parameter int                CODE_W    = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000,
   parameter logic [WIN_W-1:0]  DIV_OFS   = 8'h43,
   parameter logic [WIN_W-1:0]  EN_OFS    = 8'h46,
   parameter int                EN_POS    = 7
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] div_clk,
   output logic [NUM_CH-1:0] div_running
);

   if (NUM_CH < 1) begin : g_bad_num_ch
      $error("at least one channel required");
   end
   if (WIN_W >= ADDR_W) begin : g_bad_win_w
      $error("window must be smaller than the address space");
   end

   logic [NUM_CH-1:0][CODE_W-1:0] code;
   logic [NUM_CH-1:0]             en;
   logic [NUM_CH-1:0]             en_nxt;
   logic                          unused_en;

   assign unused_en = ^en;

   clkdiv_regs #(
      .NUM_CH    (NUM_CH),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .WIN_W     (WIN_W),
      .CODE_W    (CODE_W),
      .BASE_ADDR (BASE_ADDR),
      .DIV_OFS   (DIV_OFS),
      .EN_OFS    (EN_OFS),
      .EN_POS    (EN_POS)
   ) u_regs (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .rdata_o  (reg_rdata),
      .code_o   (code),
      .en_o     (en),
      .en_nxt_o (en_nxt)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      clkdiv_channel #(
         .CODE_W (CODE_W)
      ) u_chan (
         .clk       (clk_ref),
         .rst_n     (rst_n),
         .en_nxt_i  (en_nxt[ch]),
         .code_i    (code[ch]),
         .clk_o     (div_clk[ch]),
         .running_o (div_running[ch])
      );
   end

endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;

   localparam int BASE = 16'h2000;
   localparam int NCH  = 3;
   localparam int NEVER = 1 << 28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [2:0]  div_clk;
   logic [2:0]  div_running;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   clkdiv_bank dut (
      .clk_ref     (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .div_clk     (div_clk),
      .div_running (div_running)
   );

   always #5 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int m_code  [NCH];
   bit m_en    [NCH];
   bit m_act   [NCH];
   int m_on    [NCH];
   int m_off   [NCH];
   int m_ratio [NCH];
   bit m_drop  [NCH];

   function automatic int ratio_of(int code);
      return (code <= 1) ? 1 : (1 << (code - 1));
   endfunction

   function automatic int sess_end(int c);
      int s;
      s = m_on[c] + 2 + 3 * m_ratio[c];
      return (m_off[c] < s) ? m_off[c] : m_off[c] + 3 * m_ratio[c];
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic model_edge(input int k);
      int ch, ofs;
      if (!(rst_n && reg_wr)) return;
      ch  = (int'(reg_addr) - BASE) >>> 8;
      ofs = int'(reg_addr) & 8'hFF;
      if (int'(reg_addr) < BASE || ch >= NCH) return;
      if (ofs == 8'h43) m_code[ch] = int'(reg_wdata[2:0]);
      if (ofs == 8'h46) begin
         if (reg_wdata[7] && !m_en[ch]) begin
            if (!m_act[ch] || k >= sess_end(ch) + 1) begin
               m_act[ch]   = 1'b1;
               m_on[ch]    = k;
               m_off[ch]   = NEVER;
               m_ratio[ch] = ratio_of(m_code[ch]);
               m_drop[ch]  = 1'b0;
            end
         end else if (!reg_wdata[7] && m_en[ch]) begin
            m_off[ch] = k;
         end
         m_en[ch] = reg_wdata[7];
      end
   endtask

   task automatic compare_edge(input int k);
      for (int c = 0; c < NCH; c++) begin
         int  r, s, h;
         bit  cancel, exp_run, exp_out, pat;
         r = m_ratio[c];
         s = m_on[c] + 2 + 3 * r;
         cancel  = m_off[c] < s;
         exp_run = m_act[c] && !cancel && k >= s && k < m_off[c] + 3 * r;
         if (r == 1) begin
            exp_out = m_act[c] && !cancel && (k - 1 >= s) && (k - 1 < m_off[c]);
         end else begin
            h   = r / 2;
            pat = m_act[c] && !cancel && k >= s && (((k - s) / h) % 2 == 1);
            if (m_act[c] && k >= m_off[c] && !pat) m_drop[c] = 1'b1;
            exp_out = pat && !m_drop[c];
         end
         check(div_running[c] == exp_run, $sformatf("R6 R7 status ch%0d", c),
               int'(div_running[c]), int'(exp_run));
         check(div_clk[c] == exp_out, $sformatf("R8 R9 clock ch%0d", c),
               int'(div_clk[c]), int'(exp_out));
      end
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_code[c] = 0; m_en[c] = 0; m_act[c] = 0;
         m_on[c] = 0; m_off[c] = NEVER; m_ratio[c] = 1; m_drop[c] = 0;
      end
   end

   always begin
      @(posedge clk);
      cyc++;
      model_edge(cyc);
      #2;
      compare_edge(cyc);
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [15:0] a_of(int ch, int ofs);
      return 16'(BASE + ch * 256 + ofs);
   endfunction

   task automatic reg_write(input logic [15:0] a, input logic [7:0] d, output int k);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(posedge clk);
      #1;
      k = cyc;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic measure(input int ch, input bit level, input int k0,
                          input int exp, input string tag);
      int lat;
      lat = -1;
      for (int i = 0; i < 1000; i++) begin
         @(posedge clk);
         #3;
         if (div_running[ch] == level) begin
            lat = cyc - k0;
            break;
         end
      end
      check(lat == exp, tag, lat, exp);
   endtask

   // ---------------- sequence ----------------
   initial begin
      int k;
      bit seen;
      wait_edges(3);
      @(negedge clk);
      rst_n = 1'b1;

      for (int c = 0; c < NCH; c++) begin
         reg_read(a_of(c, 8'h43), 8'h00, "R1 reset divide code");
         reg_read(a_of(c, 8'h46), 8'h00, "R1 reset enable");
      end
      check(div_running == 3'b000, "R1 reset running", int'(div_running), 0);
      check(div_clk == 3'b000, "R1 reset clock", int'(div_clk), 0);

      // R2 / R3 / R6 / R7 on ch0, ratio 2
      reg_write(a_of(0, 8'h43), 8'hFA, k);
      reg_read(a_of(0, 8'h43), 8'h02, "R2 code readback masks upper bits");
      reg_write(a_of(0, 8'h46), 8'h7F, k);
      reg_read(a_of(0, 8'h46), 8'h00, "R3 enable bit clear stays clear");
      wait_edges(20);
      check(div_running[0] == 1'b0, "R3 no start without bit 7", int'(div_running[0]), 0);
      reg_write(a_of(0, 8'h46), 8'hFF, k);
      measure(0, 1'b1, k, 8, "R6 start latency ratio 2");
      reg_read(a_of(0, 8'h46), 8'h80, "R3 enable readback");
      wait_edges(40);
      reg_write(a_of(0, 8'h46), 8'h00, k);
      measure(0, 1'b0, k, 6, "R7 stop latency ratio 2");

      // R5: codes 0 and 1 both undivided
      reg_write(a_of(1, 8'h46), 8'h80, k);
      measure(1, 1'b1, k, 5, "R5 code 0 start latency");
      wait_edges(12);
      reg_write(a_of(1, 8'h46), 8'h00, k);
      measure(1, 1'b0, k, 3, "R7 stop latency ratio 1");
      reg_write(a_of(1, 8'h43), 8'h01, k);
      reg_write(a_of(1, 8'h46), 8'h80, k);
      measure(1, 1'b1, k, 5, "R5 code 1 start latency");
      wait_edges(12);
      reg_write(a_of(1, 8'h46), 8'h00, k);
      measure(1, 1'b0, k, 3, "R7 stop latency code 1");

      // R5: largest code, ratio 64
      reg_write(a_of(2, 8'h43), 8'h07, k);
      reg_write(a_of(2, 8'h46), 8'h80, k);
      measure(2, 1'b1, k, 194, "R5 R6 code 7 start latency");
      wait_edges(300);
      reg_write(a_of(2, 8'h46), 8'h00, k);
      measure(2, 1'b0, k, 192, "R7 code 7 stop latency");

      // R10: code rewrite while enabled
      reg_write(a_of(0, 8'h43), 8'h04, k);
      reg_write(a_of(0, 8'h46), 8'h80, k);
      measure(0, 1'b1, k, 26, "R6 start latency ratio 8");
      wait_edges(20);
      reg_write(a_of(0, 8'h43), 8'h02, k);
      reg_read(a_of(0, 8'h43), 8'h02, "R10 rewritten code reads back");
      wait_edges(40);
      reg_write(a_of(0, 8'h46), 8'h00, k);
      measure(0, 1'b0, k, 24, "R10 stop uses ratio captured at start");
      reg_write(a_of(0, 8'h46), 8'h80, k);
      measure(0, 1'b1, k, 8, "R10 new ratio applies on re-enable");
      wait_edges(20);
      reg_write(a_of(0, 8'h46), 8'h00, k);
      measure(0, 1'b0, k, 6, "R10 new ratio stop latency");

      // R11: cancelled start
      reg_write(a_of(1, 8'h43), 8'h03, k);
      reg_write(a_of(1, 8'h46), 8'h80, k);
      wait_edges(4);
      reg_write(a_of(1, 8'h46), 8'h00, k);
      seen = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(posedge clk);
         #2;
         if (div_running[1] || div_clk[1]) seen = 1'b1;
      end
      check(!seen, "R11 cancelled start stays quiet", int'(seen), 0);

      // R4: stray writes and reads
      reg_write(16'h2346, 8'hFF, k);
      reg_write(16'h1F46, 8'hFF, k);
      reg_write(a_of(1, 8'h44), 8'hFF, k);
      reg_write(a_of(1, 8'h47), 8'hFF, k);
      reg_write(a_of(1, 8'h42), 8'hFF, k);
      reg_read(a_of(1, 8'h43), 8'h03, "R4 code unchanged by stray writes");
      reg_read(a_of(1, 8'h46), 8'h00, "R4 enable unchanged by stray writes");
      reg_read(a_of(1, 8'h44), 8'h00, "R4 undefined offset reads zero");
      reg_read(16'h2346, 8'h00, "R4 address past last window reads zero");
      reg_read(16'h1F46, 8'h00, "R4 address below base reads zero");
      wait_edges(30);
      check(div_running == 3'b000, "R4 stray writes start nothing", int'(div_running), 0);

      // all channels together, different ratios
      reg_write(a_of(0, 8'h43), 8'h02, k);
      reg_write(a_of(1, 8'h43), 8'h00, k);
      reg_write(a_of(2, 8'h43), 8'h03, k);
      reg_write(a_of(0, 8'h46), 8'h80, k);
      reg_write(a_of(1, 8'h46), 8'h80, k);
      reg_write(a_of(2, 8'h46), 8'h80, k);
      wait_edges(60);
      reg_write(a_of(2, 8'h46), 8'h00, k);
      reg_write(a_of(0, 8'h46), 8'h00, k);
      reg_write(a_of(1, 8'h46), 8'h00, k);
      wait_edges(40);
      check(div_running == 3'b000, "R9 all channels stopped", int'(div_running), 0);
      check(div_clk == 3'b000, "R9 all clocks low after stop", int'(div_clk), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule